// File: doc/BRIEF.md
# Timer Capture Unit with Atomic Byte Access

This block sits beside a 16-bit up-counter and connects it to an 8-bit processor bus. It holds the counter, a capture register, and two compare values. On a chosen edge of a chosen event source, it copies the running count into the capture register. Four status flags record capture, the two compare matches and counter wrap. A mask register and a global enable turn these flags into interrupt request lines.

All four 16-bit registers share a single 8-bit holding latch. Software reads the low byte first, which also parks the high byte in the latch. A later read of the high-byte address returns that parked byte, so both halves come from the same instant. Writes go the other way round: the high byte is parked first, and the low-byte write then updates all sixteen bits in one cycle.

The capture register can also act as the counter's wrap limit. This lets a measured or programmed period set the counting range.

Top module: `tcap_unit`

## Requirements
- R1: A qualified capture event copies the current counter value into the capture register and sets flag bit 5. If a bus write to the capture register happens in the same cycle, the capture wins.
- R2: `src_sel` low takes events from `cap_in`; `src_sel` high takes them from `cmp_in`. Activity on the source that is not selected captures nothing.
- R3: The selected source passes through two synchronizing flops before edge detection. `edge_rise` high captures on rising edges only; low captures on falling edges only.
- R4: While `cnt_en` is high, the counter steps by one per clock. From 0xFFFF it goes to 0 and sets flag bit 0.
- R5: With `top_mode` high, an enabled count at the capture register's value returns to 0 and sets flag bit 0.
- R6: An enabled clock with the counter equal to compare A sets flag bit 1. With the counter equal to compare B, it sets flag bit 2.
- R7: Addresses: counter 0/1, capture 2/3, compare A 4/5, compare B 6/7 (even is low byte, odd is high byte), mask 8, flags 9. A low-byte read returns the low byte and loads the one shared holding latch with that register's high byte. A high-byte read returns the latch.
- R8: A high-byte write loads only the holding latch. A low-byte write loads {latch, data} into the register in one cycle.
- R9: Mask bits are 5 capture, 2 compare B, 1 compare A, 0 wrap. Bits 7:6 and 4:3 read zero and ignore writes. The mask resets to zero.
- R10: Each interrupt output is high only when its flag, its mask bit and `gie` are all high.
- R11: Writing one to a flag bit clears it. A set in the same cycle overrides the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Counter advance enable |
| top_mode | input | 1 | Use capture register as wrap limit |
| cap_in | input | 1 | External capture pin (asynchronous) |
| cmp_in | input | 1 | Comparator output event input (asynchronous) |
| src_sel | input | 1 | Event source select |
| edge_rise | input | 1 | 1 = rising edge, 0 = falling edge |
| gie | input | 1 | Global interrupt enable |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| irq_cap | output | 1 | Capture interrupt request |
| irq_cmpa | output | 1 | Compare A interrupt request |
| irq_cmpb | output | 1 | Compare B interrupt request |
| irq_ovf | output | 1 | Wrap interrupt request |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never high together. They also assume the bus inputs are stable around each clock edge. The stimulus drives one strobe at a time, a time unit after the rising edge. Capture inputs change only while the counter is stopped, so the expected captured value is known exactly. The source select changes only while both event inputs are low, so switching sources never produces a false edge.

// File: rtl/tcap_unit.sv
module tcap_unit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cnt_en,
  input  logic       top_mode,
  input  logic       cap_in,
  input  logic       cmp_in,
  input  logic       src_sel,
  input  logic       edge_rise,
  input  logic       gie,
  input  logic [3:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq_cap,
  output logic       irq_cmpa,
  output logic       irq_cmpb,
  output logic       irq_ovf
);
  localparam logic [7:0] MASK_LIVE = 8'h27;

  logic [15:0] cnt_q, cap_q, cmpa_q, cmpb_q;
  logic [7:0]  tmp_q, mask_q, flag_q;
  logic [2:0]  sync_q;

  wire src     = src_sel ? cmp_in : cap_in;
  wire rise    = sync_q[1] & ~sync_q[2];
  wire fall    = ~sync_q[1] & sync_q[2];
  wire cap_evt = edge_rise ? rise : fall;

  wire       wide   = ~bus_addr[3];
  wire [1:0] rsel   = bus_addr[2:1];
  wire       wr_lo  = bus_wr & wide & ~bus_addr[0];
  wire       wr_hi  = bus_wr & wide & bus_addr[0];
  wire       rd_lo  = bus_rd & wide & ~bus_addr[0];
  wire [15:0] commit = {tmp_q, bus_wdata};

  logic [15:0] sel16;
  always_comb begin
    case (rsel)
      2'd0:    sel16 = cnt_q;
      2'd1:    sel16 = cap_q;
      2'd2:    sel16 = cmpa_q;
      default: sel16 = cmpb_q;
    endcase
  end

  wire at_top = top_mode ? (cnt_q == cap_q) : (cnt_q == 16'hFFFF);
  wire wrap   = cnt_en & at_top;
  wire [7:0] set_v = {2'b00, cap_evt, 2'b00,
                      cnt_en & (cnt_q == cmpb_q),
                      cnt_en & (cnt_q == cmpa_q), wrap};
  wire [7:0] clr_v = (bus_wr && bus_addr == 4'h9) ? (bus_wdata & MASK_LIVE) : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      cnt_q  <= '0;
      cap_q  <= '0;
      cmpa_q <= '0;
      cmpb_q <= '0;
      tmp_q  <= '0;
      mask_q <= '0;
      flag_q <= '0;
    end else begin
      sync_q <= {sync_q[1:0], src};
      if (wr_lo && rsel == 2'd0) cnt_q <= commit;
      else if (cnt_en)           cnt_q <= at_top ? 16'h0000 : cnt_q + 16'd1;
      if (cap_evt)                    cap_q <= cnt_q;
      else if (wr_lo && rsel == 2'd1) cap_q <= commit;
      if (wr_lo && rsel == 2'd2) cmpa_q <= commit;
      if (wr_lo && rsel == 2'd3) cmpb_q <= commit;
      if (wr_hi)      tmp_q <= bus_wdata;
      else if (rd_lo) tmp_q <= sel16[15:8];
      if (bus_wr && bus_addr == 4'h8) mask_q <= bus_wdata & MASK_LIVE;
      flag_q <= (flag_q & ~clr_v) | set_v;
    end
  end

  always_comb begin
    if (wide)                  bus_rdata = bus_addr[0] ? tmp_q : sel16[7:0];
    else if (bus_addr == 4'h8) bus_rdata = mask_q;
    else if (bus_addr == 4'h9) bus_rdata = flag_q;
    else                       bus_rdata = 8'h00;
  end

  wire [7:0] pend = flag_q & mask_q & {8{gie}};
  assign irq_cap  = pend[5];
  assign irq_cmpb = pend[2];
  assign irq_cmpa = pend[1];
  assign irq_ovf  = pend[0];
endmodule

module tcap_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cnt_en,
  input logic        top_mode,
  input logic        gie,
  input logic [3:0]  bus_addr,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [7:0]  bus_wdata,
  input logic [15:0] cnt_q,
  input logic [15:0] cap_q,
  input logic [15:0] cmpa_q,
  input logic [7:0]  tmp_q,
  input logic [7:0]  mask_q,
  input logic [7:0]  flag_q,
  input logic        irq_cap,
  input logic        irq_cmpa,
  input logic        irq_cmpb,
  input logic        irq_ovf
);
  assert_cap_takes_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[5]) |-> cap_q == $past(cnt_q));

  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cnt_en && !top_mode && !(bus_wr && bus_addr == 4'h0) && cnt_q != 16'hFFFF)
      |-> cnt_q == $past(cnt_q) + 16'd1);

  assert_top_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cnt_en && top_mode && !(bus_wr && bus_addr == 4'h0) && cnt_q == cap_q)
      |-> (cnt_q == 16'h0000) && flag_q[0]);

  assert_temp_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_rd && bus_addr == 4'h2) |-> tmp_q == $past(cap_q[15:8]));

  assert_hi_write_only_temp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_wr && bus_addr == 4'h5) |-> cmpa_q == $past(cmpa_q) && tmp_q == $past(bus_wdata));

  assert_mask_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_wr && bus_addr == 4'h8) |-> mask_q == ($past(bus_wdata) & 8'h27));

  assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> !(irq_cap || irq_cmpa || irq_cmpb || irq_ovf));
endmodule

bind tcap_unit tcap_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .top_mode(top_mode), .gie(gie),
  .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
  .cnt_q(cnt_q), .cap_q(cap_q), .cmpa_q(cmpa_q), .tmp_q(tmp_q),
  .mask_q(mask_q), .flag_q(flag_q), .irq_cap(irq_cap), .irq_cmpa(irq_cmpa),
  .irq_cmpb(irq_cmpb), .irq_ovf(irq_ovf)
);

// File: tb/tcap_unit_tb.sv
`timescale 1ns/1ps
module tcap_unit_tb;
  logic clk = 0, rst_n = 0;
  logic cnt_en = 0, top_mode = 0, cap_in = 0, cmp_in = 0, src_sel = 0, edge_rise = 1, gie = 0;
  logic [3:0] bus_addr = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic irq_cap, irq_cmpa, irq_cmpb, irq_ovf;

  tcap_unit u_dut (.*);

  always #10 clk = ~clk;

  typedef struct { logic [7:0] exp; string req; } item_t;
  item_t q[$];
  int n_vec = 0, n_bad = 0;

  always @(negedge clk) begin
    if (bus_rd) begin
      item_t it;
      if (q.size() == 0) begin
        n_vec++; n_bad++;
        $display("FAIL scoreboard: read with no expected item, got %h", bus_rdata);
      end else begin
        it = q.pop_front();
        n_vec++;
        if (bus_rdata !== it.exp) begin
          n_bad++;
          $display("FAIL %s: addr %0d got %h expected %h", it.req, bus_addr, bus_rdata, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d, input logic en = 0);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_wr = 1; cnt_en = en;
    @(posedge clk); #1;
    bus_wr = 0; cnt_en = 0;
  endtask

  task automatic wr16(input logic [3:0] lo, input logic [15:0] v);
    wr(lo + 4'd1, v[15:8]);
    wr(lo, v[7:0]);
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string req);
    item_t it;
    @(posedge clk); #1;
    it.exp = e; it.req = req; q.push_back(it);
    bus_addr = a; bus_rd = 1;
    @(posedge clk); #1;
    bus_rd = 0;
  endtask

  task automatic rd16(input logic [3:0] lo, input logic [15:0] e, input string req);
    rd(lo, e[7:0], req);
    rd(lo + 4'd1, e[15:8], req);
  endtask

  task automatic run(input int n);
    @(posedge clk); #1; cnt_en = 1;
    repeat (n) @(posedge clk);
    #1; cnt_en = 0;
  endtask

  task automatic chk_irq(input logic [3:0] e, input string req);
    @(negedge clk);
    n_vec++;
    if ({irq_cap, irq_cmpb, irq_cmpa, irq_ovf} !== e) begin
      n_bad++;
      $display("FAIL %s: irq got %b expected %b", req, {irq_cap, irq_cmpb, irq_cmpa, irq_ovf}, e);
    end
  endtask

  task automatic settle();
    repeat (5) @(posedge clk);
  endtask

  initial begin
    #(200000 * 20);
    n_vec++; n_bad++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1 rst_n = 1;
    // R9 reset state, R10 no request
    rd(4'h8, 8'h00, "R9 mask reset");
    rd(4'h9, 8'h00, "R11 flags reset");
    chk_irq(4'b0000, "R10 reset");
    // R9 reserved bits
    wr(4'h8, 8'hFF);
    rd(4'h8, 8'h27, "R9 reserved read zero");
    // R8 high write touches only the latch
    wr(4'h5, 8'h12);
    rd(4'h4, 8'h00, "R8 low unchanged after high write");
    rd(4'h5, 8'h00, "R7 latch reloaded by low read");
    wr16(4'h4, 16'h1234);
    rd16(4'h4, 16'h1234, "R8 atomic commit cmpA");
    wr16(4'h6, 16'hABCD);
    rd16(4'h6, 16'hABCD, "R8 atomic commit cmpB");
    // R7 one shared latch
    rd(4'h4, 8'h34, "R7 low read");
    rd(4'h7, 8'h12, "R7 shared latch");
    // R1 capture on rising edge of pin
    wr16(4'h0, 16'h0100);
    wr(4'h9, 8'h27);
    @(posedge clk); #1 cap_in = 1;
    settle();
    rd16(4'h2, 16'h0100, "R1 captured count");
    rd(4'h9, 8'h20, "R1 capture flag");
    chk_irq(4'b0000, "R10 gie low");
    gie = 1;
    chk_irq(4'b1000, "R10 capture request");
    wr(4'h9, 8'h20);
    rd(4'h9, 8'h00, "R11 write one clears");
    chk_irq(4'b0000, "R10 after clear");
    // R3 falling edge
    edge_rise = 0;
    wr16(4'h0, 16'h0203);
    @(posedge clk); #1 cap_in = 0;
    settle();
    rd16(4'h2, 16'h0203, "R3 falling capture");
    wr16(4'h0, 16'h0999);
    @(posedge clk); #1 cap_in = 1;
    settle();
    rd16(4'h2, 16'h0203, "R3 rising ignored");
    @(posedge clk); #1 cap_in = 0;
    settle();
    rd16(4'h2, 16'h0999, "R3 falling again");
    // R2 source select
    edge_rise = 1; src_sel = 1;
    wr16(4'h0, 16'h0444);
    @(posedge clk); #1 cap_in = 1;
    settle();
    @(posedge clk); #1 cap_in = 0;
    settle();
    rd16(4'h2, 16'h0999, "R2 pin ignored");
    @(posedge clk); #1 cmp_in = 1;
    settle();
    rd16(4'h2, 16'h0444, "R2 comparator capture");
    @(posedge clk); #1 cmp_in = 0;
    settle();
    src_sel = 0;
    gie = 0;
    // R6 compare matches
    wr16(4'h4, 16'h0005);
    wr16(4'h6, 16'h0008);
    wr16(4'h0, 16'h0000);
    wr(4'h9, 8'h27);
    run(10);
    rd16(4'h0, 16'h000A, "R4 count steps");
    rd(4'h9, 8'h06, "R6 compare flags");
    // R4 wrap
    wr16(4'h0, 16'hFFFE);
    wr(4'h9, 8'h27);
    run(3);
    rd16(4'h0, 16'h0001, "R4 wrap value");
    rd(4'h9, 8'h01, "R4 wrap flag");
    gie = 1;
    chk_irq(4'b0001, "R10 wrap request");
    gie = 0;
    // R5 top mode
    wr16(4'h2, 16'h0003);
    wr16(4'h0, 16'h0000);
    wr(4'h9, 8'h27);
    top_mode = 1;
    run(4);
    rd16(4'h0, 16'h0000, "R5 wrap at limit");
    rd(4'h9, 8'h01, "R5 wrap flag");
    run(6);
    rd16(4'h0, 16'h0002, "R5 second period");
    top_mode = 0;
    // R11 set beats clear
    wr(4'h9, 8'h27);
    wr16(4'h0, 16'h0005);
    run(1);
    rd(4'h9, 8'h02, "R6 compare A flag");
    wr16(4'h0, 16'h0005);
    wr(4'h9, 8'h02, 1'b1);
    rd(4'h9, 8'h02, "R11 set wins");
    wr(4'h9, 8'h02);
    rd(4'h9, 8'h00, "R11 clear");
    repeat (3) @(posedge clk);
    if (q.size() != 0) begin
      n_vec++; n_bad++;
      $display("FAIL scoreboard: %0d items left expected 0", q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule